// File: doc/BRIEF.md
# DRAM Auto-Refresh Scheduler

This block tells a DDR SDRAM command arbiter when refreshes are owed. A free-running tick counter turns the clock frequency and the retention window into a refresh interval. Each interval adds one refresh credit. Each AUTO REFRESH that the arbiter reports as issued takes one credit away.

While credits are outstanding, the block raises a normal request, so the arbiter can fit refreshes into idle slots. When the count of postponed refreshes reaches its legal ceiling of eight, the block raises an urgent request. The arbiter must then service that request before any other command.

A grade input selects between the normal retention window and a window four times shorter for hot operation. After every acknowledged refresh, a busy flag holds off row activation for a parameterised recovery time. A tick that would push the credit count past the ceiling is dropped and sets a sticky error flag.

Top module: `refresh_sched`

## Requirements
- R1: With `hot_grade` low, a refresh credit is added every `CLK_KHZ*WIN_NORM_MS/ROWS` cycles. The first credit shows on `pend_cnt` one cycle after that many counting cycles have elapsed since reset was released.
- R2: With `hot_grade` high, the interval is `CLK_KHZ*WIN_HOT_MS/ROWS` cycles. If the grade shortens the interval while the count already exceeds the new limit, a credit is added on the next edge.
- R3: `pend_cnt` never exceeds `MAX_POSTPONE` (8).
- R4: `rf_req` is high exactly when `pend_cnt` is non-zero.
- R5: `rf_urgent` is high exactly when `pend_cnt` equals `MAX_POSTPONE`.
- R6: An `rf_ack` sampled while `pend_cnt` is non-zero lowers the count by one. An `rf_ack` sampled while the count is zero is ignored: the count and `act_block` do not change.
- R7: A credit arriving while `pend_cnt` equals `MAX_POSTPONE` and no acknowledge is present is dropped and sets `ovf_err`. `ovf_err` stays set until reset.
- R8: `act_block` goes high on the edge after an accepted acknowledge and stays high for exactly `TRFC_CYC` cycles. A further accepted acknowledge restarts the period.
- R9: A credit and an accepted acknowledge on the same edge leave `pend_cnt` unchanged and never set `ovf_err`, even at the ceiling.
- R10: While reset is active, and for two edges after `rst_n` rises, all outputs are zero and no credit is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hot_grade | input | 1 | 1 selects the short retention window |
| rf_ack | input | 1 | Arbiter issued an AUTO REFRESH this cycle |
| rf_req | output | 1 | Refresh credits outstanding |
| rf_urgent | output | 1 | Postponement ceiling reached, service first |
| act_block | output | 1 | Refresh recovery in progress, no ACTIVE allowed |
| ovf_err | output | 1 | Sticky: a credit was lost at the ceiling |
| pend_cnt | output | $clog2(MAX_POSTPONE+1) | Outstanding refresh credits |

## Verification
The bench uses a reduced configuration of 8-cycle and 2-cycle intervals and a 3-cycle recovery, and sweeps every cycle against an arithmetic model.

It drives the count to the ceiling and past it. A counter that wrapped to zero, or that failed to latch the error, would be caught there. It lines up an acknowledge with a credit at the ceiling, where a design that flagged overflow or changed the count would fail. It sends acknowledges while nothing is pending, which exposes a count that underflows or a recovery flag that starts anyway. It also switches the grade while a count is in progress, which exposes an interval limit tested only for equality and therefore missed.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // Refresh interval in clocks for a given window.
  function automatic longint unsigned ival_cycles(longint unsigned khz,
                                                  longint unsigned win_ms,
                                                  longint unsigned rows);
    return (khz * win_ms) / rows;
  endfunction
endpackage

// File: rtl/rfsh_tick_gen.sv
module rfsh_tick_gen #(
  parameter int unsigned LIM_NORM = 1562,
  parameter int unsigned LIM_HOT  = 390,
  parameter int unsigned CW       = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  output logic tick
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_m1;

  always_comb begin
    lim_m1 = hot ? CW'(LIM_HOT - 1) : CW'(LIM_NORM - 1);
    tick   = (cnt_q >= lim_m1);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1/R2: intervals are at least two cycles, so ticks never repeat back to back
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int unsigned MAXP = 8,
  parameter int unsigned PW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ack,
  output logic          ack_ok,
  output logic [PW-1:0] pend,
  output logic          ovf
);
  logic [PW-1:0] pend_d;
  logic          ovf_d;
  logic          at_max, inc, dec;

  always_comb begin
    at_max = (pend == PW'(MAXP));
    ack_ok = ack && (pend != '0);
    dec    = ack_ok;
    inc    = tick && (!at_max || dec);
    pend_d = pend;
    if (inc && !dec)      pend_d = pend + 1'b1;
    else if (dec && !inc) pend_d = pend - 1'b1;
    ovf_d  = ovf | (tick && at_max && !dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ovf  <= 1'b0;
    end else begin
      pend <= pend_d;
      ovf  <= ovf_d;
    end
  end

  p_pend_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(MAXP));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  p_ack_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0 && !tick) |=> pend == '0);
  p_tick_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ack && pend != '0) |=> $stable(pend));
endmodule

// File: rtl/rfsh_busy_timer.sv
module rfsh_busy_timer #(
  parameter int unsigned TRFC = 14,
  parameter int unsigned BW   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [BW-1:0] left_q, left_d;

  always_comb begin
    if (start)               left_d = BW'(TRFC);
    else if (left_q != '0)   left_d = left_q - 1'b1;
    else                     left_d = left_q;
    busy = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 200000,
  parameter int unsigned ROWS         = 8192,
  parameter int unsigned WIN_NORM_MS  = 64,
  parameter int unsigned WIN_HOT_MS   = 16,
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned TRFC_CYC     = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_grade,
  input  logic rf_ack,
  output logic rf_req,
  output logic rf_urgent,
  output logic act_block,
  output logic ovf_err,
  output logic [$clog2(MAX_POSTPONE+1)-1:0] pend_cnt
);
  localparam int unsigned LIM_NORM = int'(ival_cycles(CLK_KHZ, WIN_NORM_MS, ROWS));
  localparam int unsigned LIM_HOT  = int'(ival_cycles(CLK_KHZ, WIN_HOT_MS, ROWS));
  localparam int unsigned CW = $clog2(LIM_NORM + 1);
  localparam int unsigned PW = $clog2(MAX_POSTPONE + 1);
  localparam int unsigned BW = $clog2(TRFC_CYC + 1);

  // Reset: asserted asynchronously, released after two edges
  logic rs_a, rs_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end

  logic tick, ack_ok;

  rfsh_tick_gen #(.LIM_NORM(LIM_NORM), .LIM_HOT(LIM_HOT), .CW(CW)) u_tick (
    .clk(clk), .rst_n(rs_b), .hot(hot_grade), .tick(tick));

  rfsh_credit #(.MAXP(MAX_POSTPONE), .PW(PW)) u_credit (
    .clk(clk), .rst_n(rs_b), .tick(tick), .ack(rf_ack),
    .ack_ok(ack_ok), .pend(pend_cnt), .ovf(ovf_err));

  rfsh_busy_timer #(.TRFC(TRFC_CYC), .BW(BW)) u_busy (
    .clk(clk), .rst_n(rs_b), .start(ack_ok), .busy(act_block));

  always_comb begin
    rf_req    = (pend_cnt != '0);
    rf_urgent = (pend_cnt == PW'(MAX_POSTPONE));
  end

  p_urgent_req_r5: assert property (@(posedge clk) disable iff (!rs_b)
    rf_urgent |-> rf_req);
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rs_b)
    !rf_req |=> (pend_cnt <= PW'(1)));
endmodule

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  localparam int CLK_NS = 10;
  localparam int LN = 8, LH = 2, MAXP = 8, TR = 3;

  logic clk = 1'b0;
  logic rst_n, hot_grade, rf_ack;
  logic rf_req, rf_urgent, act_block, ovf_err;
  logic [3:0] pend_cnt;
  int total = 0, bad = 0;
  int mcnt, mpend, mbusy;
  bit movf;

  always #(CLK_NS/2) clk = ~clk;

  refresh_sched #(.CLK_KHZ(1), .ROWS(8), .WIN_NORM_MS(64), .WIN_HOT_MS(16),
                  .MAX_POSTPONE(MAXP), .TRFC_CYC(TR)) uut (
    .clk(clk), .rst_n(rst_n), .hot_grade(hot_grade), .rf_ack(rf_ack),
    .rf_req(rf_req), .rf_urgent(rf_urgent), .act_block(act_block),
    .ovf_err(ovf_err), .pend_cnt(pend_cnt));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2/R3 pend", pend_cnt, mpend);
    chk("R4 req", rf_req, mpend != 0);
    chk("R5 urgent", rf_urgent, mpend == MAXP);
    chk("R8 busy", act_block, mbusy != 0);
    chk("R7 ovf", ovf_err, movf);
  endtask

  task automatic do_reset(bit hot);
    rst_n = 1'b0; hot_grade = hot; rf_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset req", rf_req, 0);
    chk("R10 reset pend", pend_cnt, 0);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R10 sync hold pend", pend_cnt, 0);
    chk("R10 sync hold busy", act_block, 0);
    mcnt = 0; mpend = 0; mbusy = 0; movf = 0;
  endtask

  task automatic step(bit ack);
    bit tk, aok;
    int lim;
    rf_ack = ack;
    @(posedge clk);
    lim = hot_grade ? LH : LN;
    tk  = (mcnt >= lim - 1);
    mcnt = tk ? 0 : mcnt + 1;
    aok = ack && (mpend != 0);
    if (tk && mpend == MAXP && !aok) movf = 1;
    if (tk && !aok && mpend < MAXP) mpend++;
    else if (aok && !tk) mpend--;
    if (aok) mbusy = TR;
    else if (mbusy > 0) mbusy--;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(CLK_NS * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Normal grade: fill to ceiling then overflow (R1 R3 R5 R7), ack at zero (R6)
    do_reset(1'b0);
    step(1'b1);
    chk("R6 ack at zero ignored busy", act_block, 0);
    for (int i = 0; i < 80; i++) step(1'b0);
    chk("R7 ovf latched", ovf_err, 1);
    // drain with sparse acks, recovery restart (R6 R8)
    for (int i = 0; i < 40; i++) step(i % 3 == 0);
    for (int i = 0; i < 30; i++) step(1'b1);
    chk("R6 drained", pend_cnt, 0);

    // Hot grade: tick and ack together at ceiling (R2 R9)
    do_reset(1'b1);
    for (int i = 0; i < 17; i++) step(1'b0);
    chk("R2 hot ceiling", pend_cnt, MAXP);
    step(1'b1);
    chk("R9 no ovf on tick+ack", ovf_err, 0);
    chk("R9 pend held", pend_cnt, MAXP);
    for (int i = 0; i < 20; i++) step(i % 2 == 1);

    // Grade switch mid-count (R2)
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) step(1'b0);
    hot_grade = 1'b1;
    step(1'b0);
    chk("R2 switch credits", pend_cnt, 1);
    for (int i = 0; i < 12; i++) step(i % 4 == 0);
    hot_grade = 1'b0;
    for (int i = 0; i < 30; i++) step(i % 5 == 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule